// File: doc/BRIEF.md
# Per-Lane Buffer Address Generator with Swizzle

This block turns one vector buffer access into a stream of byte addresses, one for each active lane of a vector of up to 64 lanes. A start pulse captures a buffer descriptor (base address, stride, record count, thread-id add enable, a format field that widens the stride, swizzle enable, index-stride code and element-size code), a scalar offset, an instruction offset and the execution mask. The block then walks the lanes in ascending order, one lane per clock. For each lane it forms an index and an offset, checks them against the buffer bounds and computes the address. The address is either linear or swizzled: in swizzled mode index and offset are split into power-of-two tiles.

Out-of-bounds lanes never fault. They are recorded in an out-of-bounds mask and dropped from the address stream. When the sweep ends, an effective mask is published for the store path. It equals the execution mask with every out-of-bounds lane removed. The per-lane index and offset vectors are read live during the sweep, so the requester holds them steady while `busy` is high.

Top module: `buf_lane_agen`

## Requirements
- R1: After reset, `busy`, `done`, `addrValid`, `oobMask` and `effMask` are all zero.
- R2: A `start` pulse while idle begins a sweep. Lane k's result appears k+1 cycles after the `start` edge. `done` is high for exactly one cycle, in the cycle that carries lane NUM_LANES-1. `busy` is low in that cycle. A `start` pulse, or any change of the descriptor, scalar offset, instruction offset or execution mask, has no effect while `busy` is high.
- R3: The effective stride is `descStride` plus `descDataFmt` shifted left by 14 when `descTidEn` is 1. When `descTidEn` is 0 it is `descStride` alone.
- R4: A lane's index is its `laneIdx` field (lane k at bits [k*32 +: 32]) plus k when `descTidEn` is 1, and the field alone when it is 0. A lane's offset is its `laneOff` field (lane k at bits [k*32 +: 32]) plus `instOff`.
- R5: When `descSwzEn` is 0, the address is `descBase` + `scalarOff` + stride*index + offset, taken modulo 2^48.
- R6: When `descSwzEn` is 1, let the index tile I be 8 shifted left by `descIdxStrideCode` and the element size E be 2 shifted left by `descElemSizeCode`. The address is `descBase` + `scalarOff` + ((index/I)*stride + (offset/E)*E)*I + (index mod I)*E + (offset mod E), taken modulo 2^48.
- R7: When the effective stride is 0 or `descSwzEn` is 0, a lane is out of bounds when offset + stride*index is at least `descRecords` - `scalarOff`. The limit is 0 when `scalarOff` exceeds `descRecords`, so every enabled lane is then out of bounds.
- R8: When the effective stride is nonzero and `descSwzEn` is 1, a lane is out of bounds when its index is at least `descRecords`, whatever its offset.
- R9: `addrValid` is high for a lane only when its execution-mask bit is 1 and it is in bounds. A lane whose execution-mask bit is 0 produces no address and its `oobMask` bit is 0. `oobMask` is cleared at start and holds its value after the sweep.
- R10: In the `done` cycle, `effMask` equals the captured execution mask AND NOT `oobMask`, including the verdict of the last lane. It holds that value until the next sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sweep when idle |
| descBase | input | 48 | Buffer base byte address |
| descStride | input | 14 | Stride field |
| descRecords | input | 32 | Record count / byte limit |
| descTidEn | input | 1 | Add lane number to index, widen stride |
| descDataFmt | input | 4 | Format field used as stride high bits |
| descSwzEn | input | 1 | Swizzled addressing enable |
| descIdxStrideCode | input | 2 | Index tile code (tile = 8 << code) |
| descElemSizeCode | input | 2 | Element size code (size = 2 << code) |
| scalarOff | input | 32 | Scalar byte offset |
| instOff | input | 12 | Instruction byte offset |
| laneIdx | input | 2048 | Per-lane index, 32 bits per lane |
| laneOff | input | 2048 | Per-lane offset, 32 bits per lane |
| execMask | input | 64 | Execution mask, bit k for lane k |
| busy | output | 1 | Sweep in progress |
| addrValid | output | 1 | `addrOut` holds an address for `addrLane` |
| addrLane | output | 6 | Lane number of the current result |
| addrOut | output | 48 | Lane byte address |
| oobMask | output | 64 | Out-of-bounds lanes of the current/last sweep |
| effMask | output | 64 | Execution mask without out-of-bounds lanes |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The final lane's bounds verdict and the publication of the effective mask fall in the same clock edge, so an out-of-bounds last lane is the case that tells them apart. Sweeps are set up with lane 63 out of bounds under the linear rule, under the saturated limit and under the swizzle rule. In each of them, `effMask` bit 63 must already be clear in the `done` cycle. A second overlap is a fresh `start` arriving while a sweep is in flight, together with changed descriptor and mask inputs. It is judged by the stream and the masks continuing to match the first descriptor, and by `done` arriving on its original schedule.

// File: rtl/buf_agen_pkg.sv
package buf_agen_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch descriptor, clear masks
    logic step;      // evaluate the current lane
    logic last;      // current lane is the final one
  } agenStrobe_t;

  localparam int CALC_W = 64;

endpackage

// File: rtl/buf_agen_ctrl.sv
module buf_agen_ctrl
  import buf_agen_pkg::*;
#(
  parameter int NUM_LANES = 64,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output agenStrobe_t       strobe,
  output logic [LANE_W-1:0] curLane,
  output logic              busy,
  output logic              done
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  logic atLast;
  assign atLast = (curLane == LAST_LANE);

  always_comb begin
    strobe.capture = start && !busy;
    strobe.step    = busy;
    strobe.last    = busy && atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      curLane <= '0;
    end else begin
      done <= 1'b0;
      if (strobe.capture) begin
        busy    <= 1'b1;
        curLane <= '0;
      end else if (busy) begin
        if (atLast) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          curLane <= curLane + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/buf_agen_dp.sv
module buf_agen_dp
  import buf_agen_pkg::*;
#(
  parameter int NUM_LANES = 64,
  parameter int ADDR_W    = 48,
  parameter int STRIDE_W  = 14,
  parameter int DFMT_W    = 4,
  parameter int REC_W     = 32,
  parameter int SOFF_W    = 32,
  parameter int IOFF_W    = 12,
  parameter int IDX_W     = 32,
  parameter int OFF_W     = 32,
  localparam int LANE_W   = $clog2(NUM_LANES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  agenStrobe_t                strobe,
  input  logic [LANE_W-1:0]          curLane,
  input  logic [ADDR_W-1:0]          descBase,
  input  logic [STRIDE_W-1:0]        descStride,
  input  logic [REC_W-1:0]           descRecords,
  input  logic                       descTidEn,
  input  logic [DFMT_W-1:0]          descDataFmt,
  input  logic                       descSwzEn,
  input  logic [1:0]                 descIdxStrideCode,
  input  logic [1:0]                 descElemSizeCode,
  input  logic [SOFF_W-1:0]          scalarOff,
  input  logic [IOFF_W-1:0]          instOff,
  input  logic [NUM_LANES*IDX_W-1:0] laneIdx,
  input  logic [NUM_LANES*OFF_W-1:0] laneOff,
  input  logic [NUM_LANES-1:0]       execMask,
  output logic                       addrValid,
  output logic [LANE_W-1:0]          addrLane,
  output logic [ADDR_W-1:0]          addrOut,
  output logic [NUM_LANES-1:0]       oobMask,
  output logic [NUM_LANES-1:0]       effMask
);

  // Unpack flattened lane vectors
  logic [IDX_W-1:0] idxArr [NUM_LANES];
  logic [OFF_W-1:0] offArr [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_unpack
    assign idxArr[g] = laneIdx[g*IDX_W +: IDX_W];
    assign offArr[g] = laneOff[g*OFF_W +: OFF_W];
  end

  // Captured descriptor state
  logic [CALC_W-1:0]    strideQ;
  logic [CALC_W-1:0]    startAddrQ;
  logic [CALC_W-1:0]    recordsQ;
  logic [CALC_W-1:0]    limitQ;
  logic [CALC_W-1:0]    instOffQ;
  logic                 tidQ;
  logic                 swzQ;
  logic [2:0]           idxShQ;
  logic [2:0]           offShQ;
  logic [NUM_LANES-1:0] execQ;

  // Capture-time derivations
  logic [CALC_W-1:0] strideNew;
  logic [CALC_W-1:0] recordsNew;
  logic [CALC_W-1:0] soffNew;

  always_comb begin
    recordsNew = {{(CALC_W-REC_W){1'b0}}, descRecords};
    soffNew    = {{(CALC_W-SOFF_W){1'b0}}, scalarOff};
    strideNew  = {{(CALC_W-STRIDE_W){1'b0}}, descStride};
    if (descTidEn)
      strideNew = strideNew + ({{(CALC_W-DFMT_W){1'b0}}, descDataFmt} << 14);
  end

  // Per-lane evaluation
  logic [CALC_W-1:0] laneIdxW;
  logic [CALC_W-1:0] laneOffW;
  logic [CALC_W-1:0] linSum;
  logic [CALC_W-1:0] idxHi, idxLo, offHi, offLo;
  logic [CALC_W-1:0] swzSum;
  logic [CALC_W-1:0] fullAddr;
  logic              oobLin, oobSwz, oobRaw, execBit, oobHit;
  logic [NUM_LANES-1:0] oobNext;

  always_comb begin
    laneIdxW = {{(CALC_W-IDX_W){1'b0}}, idxArr[curLane]};
    if (tidQ)
      laneIdxW = laneIdxW + {{(CALC_W-LANE_W){1'b0}}, curLane};
    laneOffW = {{(CALC_W-OFF_W){1'b0}}, offArr[curLane]} + instOffQ;

    linSum = strideQ * laneIdxW + laneOffW;

    // Power-of-two split: shifts and masks
    idxHi = laneIdxW >> idxShQ;
    idxLo = laneIdxW & ((CALC_W'(1) << idxShQ) - CALC_W'(1));
    offHi = laneOffW >> offShQ;
    offLo = laneOffW & ((CALC_W'(1) << offShQ) - CALC_W'(1));
    swzSum = ((idxHi * strideQ + (offHi << offShQ)) << idxShQ)
           + (idxLo << offShQ) + offLo;

    fullAddr = startAddrQ + (swzQ ? swzSum : linSum);

    oobLin  = (linSum >= limitQ);
    oobSwz  = (laneIdxW >= recordsQ);
    oobRaw  = (swzQ && (strideQ != '0)) ? oobSwz : oobLin;
    execBit = execQ[curLane];
    oobHit  = execBit && oobRaw;
    oobNext = oobMask | ({{(NUM_LANES-1){1'b0}}, oobHit} << curLane);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strideQ    <= '0;
      startAddrQ <= '0;
      recordsQ   <= '0;
      limitQ     <= '0;
      instOffQ   <= '0;
      tidQ       <= 1'b0;
      swzQ       <= 1'b0;
      idxShQ     <= 3'd3;
      offShQ     <= 3'd1;
      execQ      <= '0;
      addrValid  <= 1'b0;
      addrLane   <= '0;
      addrOut    <= '0;
      oobMask    <= '0;
      effMask    <= '0;
    end else begin
      if (strobe.capture) begin
        strideQ    <= strideNew;
        startAddrQ <= {{(CALC_W-ADDR_W){1'b0}}, descBase} + soffNew;
        recordsQ   <= recordsNew;
        limitQ     <= (soffNew > recordsNew) ? '0 : (recordsNew - soffNew);
        instOffQ   <= {{(CALC_W-IOFF_W){1'b0}}, instOff};
        tidQ       <= descTidEn;
        swzQ       <= descSwzEn;
        idxShQ     <= 3'd3 + {1'b0, descIdxStrideCode};
        offShQ     <= 3'd1 + {1'b0, descElemSizeCode};
        execQ      <= execMask;
        oobMask    <= '0;
        addrValid  <= 1'b0;
      end else if (strobe.step) begin
        addrValid <= execBit && !oobRaw;
        addrLane  <= curLane;
        addrOut   <= fullAddr[ADDR_W-1:0];
        oobMask   <= oobNext;
        if (strobe.last)
          effMask <= execQ & ~oobNext;
      end else begin
        addrValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/buf_lane_agen.sv
module buf_lane_agen
  import buf_agen_pkg::*;
#(
  parameter int NUM_LANES = 64,
  parameter int ADDR_W    = 48,
  parameter int STRIDE_W  = 14,
  parameter int DFMT_W    = 4,
  parameter int REC_W     = 32,
  parameter int SOFF_W    = 32,
  parameter int IOFF_W    = 12,
  parameter int IDX_W     = 32,
  parameter int OFF_W     = 32,
  localparam int LANE_W   = $clog2(NUM_LANES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          descBase,
  input  logic [STRIDE_W-1:0]        descStride,
  input  logic [REC_W-1:0]           descRecords,
  input  logic                       descTidEn,
  input  logic [DFMT_W-1:0]          descDataFmt,
  input  logic                       descSwzEn,
  input  logic [1:0]                 descIdxStrideCode,
  input  logic [1:0]                 descElemSizeCode,
  input  logic [SOFF_W-1:0]          scalarOff,
  input  logic [IOFF_W-1:0]          instOff,
  input  logic [NUM_LANES*IDX_W-1:0] laneIdx,
  input  logic [NUM_LANES*OFF_W-1:0] laneOff,
  input  logic [NUM_LANES-1:0]       execMask,
  output logic                       busy,
  output logic                       addrValid,
  output logic [LANE_W-1:0]          addrLane,
  output logic [ADDR_W-1:0]          addrOut,
  output logic [NUM_LANES-1:0]       oobMask,
  output logic [NUM_LANES-1:0]       effMask,
  output logic                       done
);

  agenStrobe_t       strobe;
  logic [LANE_W-1:0] curLane;

  buf_agen_ctrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .curLane(curLane), .busy(busy), .done(done)
  );

  buf_agen_dp #(
    .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W),
    .DFMT_W(DFMT_W), .REC_W(REC_W), .SOFF_W(SOFF_W), .IOFF_W(IOFF_W),
    .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curLane(curLane),
    .descBase(descBase), .descStride(descStride), .descRecords(descRecords),
    .descTidEn(descTidEn), .descDataFmt(descDataFmt), .descSwzEn(descSwzEn),
    .descIdxStrideCode(descIdxStrideCode), .descElemSizeCode(descElemSizeCode),
    .scalarOff(scalarOff), .instOff(instOff),
    .laneIdx(laneIdx), .laneOff(laneOff), .execMask(execMask),
    .addrValid(addrValid), .addrLane(addrLane), .addrOut(addrOut),
    .oobMask(oobMask), .effMask(effMask)
  );

endmodule

// File: rtl/buf_agen_chk.sv
module buf_agen_chk #(
  parameter int NUM_LANES = 64,
  parameter int LANE_W    = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic [NUM_LANES-1:0] execMask,
  input logic                 busy,
  input logic                 done,
  input logic                 addrValid,
  input logic [LANE_W-1:0]    addrLane,
  input logic [NUM_LANES-1:0] oobMask,
  input logic [NUM_LANES-1:0] effMask
);

  logic [NUM_LANES-1:0] chkExec;

  always_ff @(posedge clk) begin
    if (!rstN) chkExec <= '0;
    else if (start && !busy) chkExec <= execMask;
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r2_valid_in_sweep: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> $past(busy));

  a_r9_valid_needs_exec: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (chkExec[addrLane] && !oobMask[addrLane]));

  a_r9_oob_within_exec: assert property (@(posedge clk) disable iff (!rstN)
    (oobMask & ~chkExec) == '0);

  a_r10_eff_split: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (((effMask | oobMask) == chkExec) && ((effMask & oobMask) == '0)));

endmodule

bind buf_lane_agen buf_agen_chk #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .execMask(execMask), .busy(busy),
  .done(done), .addrValid(addrValid), .addrLane(addrLane),
  .oobMask(oobMask), .effMask(effMask)
);

// File: tb/buf_lane_agen_bench.sv
`timescale 1ns/1ps
module buf_lane_agen_bench;

  localparam int NL = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [47:0]   descBase = '0;
  logic [13:0]   descStride = '0;
  logic [31:0]   descRecords = '0;
  logic          descTidEn = 1'b0;
  logic [3:0]    descDataFmt = '0;
  logic          descSwzEn = 1'b0;
  logic [1:0]    descIdxStrideCode = '0;
  logic [1:0]    descElemSizeCode = '0;
  logic [31:0]   scalarOff = '0;
  logic [11:0]   instOff = '0;
  logic [NL*32-1:0] laneIdx = '0;
  logic [NL*32-1:0] laneOff = '0;
  logic [NL-1:0] execMask = '0;
  logic          busy, addrValid, done;
  logic [5:0]    addrLane;
  logic [47:0]   addrOut;
  logic [NL-1:0] oobMask, effMask;

  int checks = 0;
  int fails  = 0;

  // Saved copy of the request at sweep start
  longint unsigned sBase, sStride, sRec, sSoff, sIoff;
  bit sTid, sSwz;
  int sIc, sEc;
  bit [NL-1:0] sExec;
  longint unsigned idxV [NL];
  longint unsigned offV [NL];

  buf_lane_agen u_buf_lane_agen (
    .clk(clk), .rstN(rstN), .start(start), .descBase(descBase),
    .descStride(descStride), .descRecords(descRecords), .descTidEn(descTidEn),
    .descDataFmt(descDataFmt), .descSwzEn(descSwzEn),
    .descIdxStrideCode(descIdxStrideCode), .descElemSizeCode(descElemSizeCode),
    .scalarOff(scalarOff), .instOff(instOff), .laneIdx(laneIdx),
    .laneOff(laneOff), .execMask(execMask), .busy(busy),
    .addrValid(addrValid), .addrLane(addrLane), .addrOut(addrOut),
    .oobMask(oobMask), .effMask(effMask), .done(done)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkMask(input string tag, input logic [NL-1:0] act,
                           input logic [NL-1:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  function automatic void model(input int k, output longint unsigned a,
                                output bit oob);
    longint unsigned str, idx, off, sum, lim, it, es;
    str = sTid ? ((sStride) + ((longint'(descDataFmtS)) << 14)) : sStride;
    idx = idxV[k] + (sTid ? longint'(k) : 0);
    off = offV[k] + sIoff;
    if (sSwz) begin
      it  = 64'd8 << sIc;
      es  = 64'd2 << sEc;
      sum = ((idx / it) * str + (off / es) * es) * it + (idx % it) * es + (off % es);
    end else begin
      sum = str * idx + off;
    end
    a = (sBase + sSoff + sum) & 64'hFFFF_FFFF_FFFF;
    if (sSwz && str != 0) begin
      oob = (idx >= sRec);
    end else begin
      lim = (sSoff > sRec) ? 0 : sRec - sSoff;
      oob = (str * idx + off >= lim);
    end
    if (!sExec[k]) oob = 1'b0;
  endfunction

  longint unsigned descDataFmtS;

  task automatic loadLanes();
    for (int k = 0; k < NL; k++) begin
      laneIdx[k*32 +: 32] = idxV[k][31:0];
      laneOff[k*32 +: 32] = offV[k][31:0];
    end
  endtask

  // Runs one sweep; optionally pulses start with altered inputs mid-sweep
  task automatic runSweep(input string tag, input bit midPulse);
    longint unsigned ea;
    bit eo;
    logic [NL-1:0] expOob;
    bit seqOk, doneOk, valOk;
    loadLanes();
    sBase = descBase; sStride = descStride; sRec = descRecords;
    sSoff = scalarOff; sIoff = instOff; sTid = descTidEn; sSwz = descSwzEn;
    sIc = descIdxStrideCode; sEc = descElemSizeCode; sExec = execMask;
    descDataFmtS = descDataFmt;
    expOob = '0; seqOk = 1'b1; doneOk = 1'b1; valOk = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < NL; c++) begin
      if (midPulse && c == 10) begin
        start = 1'b1; descBase = descBase + 48'h1000; execMask = ~execMask;
        descRecords = 32'd0;
      end
      @(negedge clk);
      if (midPulse && c == 10) start = 1'b0;
      model(c, ea, eo);
      expOob[c] = eo;
      if (addrValid !== (sExec[c] && !eo)) begin
        valOk = 1'b0;
        check(1'b0, {tag, " R9 valid lane"}, addrValid, sExec[c] && !eo);
      end else if (addrValid) begin
        if (addrLane !== c[5:0]) seqOk = 1'b0;
        check(addrOut === ea[47:0], {tag, " R5/R6 address"}, addrOut, ea);
      end
      if (done !== (c == NL - 1)) doneOk = 1'b0;
    end
    check(seqOk && valOk, {tag, " R2 lane order"}, seqOk, 1);
    check(doneOk && busy === 1'b0, {tag, " R2 done timing"}, done, 1);
    checkMask({tag, " R7/R8 oobMask"}, oobMask, expOob);
    checkMask({tag, " R10 effMask"}, effMask, sExec & ~expOob);
    @(negedge clk);
    check(done === 1'b0, {tag, " R2 done one cycle"}, done, 0);
    checkMask({tag, " R9 oobMask holds"}, oobMask, expOob);
  endtask

  task automatic setDesc(input longint unsigned base, input int stride,
                         input longint unsigned rec, input bit tid, input int dfmt,
                         input bit swz, input int ic, input int ec,
                         input longint unsigned soff, input int ioff);
    descBase = base[47:0]; descStride = stride[13:0]; descRecords = rec[31:0];
    descTidEn = tid; descDataFmt = dfmt[3:0]; descSwzEn = swz;
    descIdxStrideCode = ic[1:0]; descElemSizeCode = ec[1:0];
    scalarOff = soff[31:0]; instOff = ioff[11:0];
  endtask

  task automatic t_reset();
    check(busy === 0 && done === 0 && addrValid === 0, "R1 reset controls", {busy, done, addrValid}, 0);
    checkMask("R1 reset oobMask", oobMask, '0);
    checkMask("R1 reset effMask", effMask, '0);
  endtask

  task automatic t_linear();
    for (int k = 0; k < NL; k++) begin idxV[k] = k * 3; offV[k] = k * 5 + 1; end
    setDesc(48'h1234_0000_0000, 16, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 100, 7);
    execMask = '1;
    runSweep("linear R4 R5", 0);
  endtask

  task automatic t_tid();
    for (int k = 0; k < NL; k++) begin idxV[k] = 2 * k; offV[k] = 3 * k; end
    setDesc(48'hFFFF_FFF0_0000, 8, 32'hFFFF_FFFF, 1, 2, 0, 0, 0, 12, 0);
    execMask = 64'hFFFF_0000_FFFF_FFFF;
    runSweep("tid R3 R4", 0);
  endtask

  task automatic t_swizzle();
    for (int k = 0; k < NL; k++) begin idxV[k] = k * 7 + 3; offV[k] = k * 11; end
    setDesc(48'h0000_4000_0000, 12, 32'hFFFF_FFFF, 0, 0, 1, 1, 2, 64, 5);
    execMask = '1;
    runSweep("swizzle R6", 0);
    setDesc(48'h0000_0800_0000, 3, 32'hFFFF_FFFF, 1, 1, 1, 3, 0, 0, 33);
    runSweep("swizzle tid R6", 0);
  endtask

  task automatic t_oobLinear();
    for (int k = 0; k < NL; k++) begin idxV[k] = k; offV[k] = 0; end
    setDesc(48'h100, 4, 8 + 4 * 32, 0, 0, 0, 0, 0, 8, 0);
    execMask = 64'hF0F0_F0F0_FFFF_00FF;
    runSweep("linear bound R7", 0);
    setDesc(48'h100, 4, 20, 0, 0, 0, 0, 0, 21, 0);
    execMask = 64'hFFFF_FFFF_0000_FFFF;
    runSweep("saturated limit R7", 0);
  endtask

  task automatic t_oobSwizzle();
    for (int k = 0; k < NL; k++) begin idxV[k] = k; offV[k] = 32'h7FFF_0000; end
    setDesc(48'h2000, 4, 40, 0, 0, 1, 0, 0, 0, 0);
    execMask = '1;
    runSweep("swizzle bound R8", 0);
    for (int k = 0; k < NL; k++) begin idxV[k] = 1000; offV[k] = k; end
    setDesc(48'h2000, 0, 20, 0, 0, 1, 0, 0, 0, 0);
    runSweep("zero stride swizzle R7 R8", 0);
  endtask

  task automatic t_busyStart();
    for (int k = 0; k < NL; k++) begin idxV[k] = k; offV[k] = k; end
    setDesc(48'h9000, 2, 100, 0, 0, 0, 0, 0, 0, 0);
    execMask = 64'h0F0F_0F0F_0F0F_0F0F;
    runSweep("restart while busy R2", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_tid();
    t_swizzle();
    t_oobLinear();
    t_oobSwizzle();
    t_busyStart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule